// File: doc/BRIEF.md
# Eight-Pin Port Expander Register Core

This block holds the registers and pin logic of an eight-pin port expander that sits behind a byte-oriented serial target. A separate front end handles the bit-level signalling, address matching and acknowledges. It hands this core three strobes: one that marks the start of a transaction, one that delivers a written byte, and one that asks for a read byte. The core keeps four byte-wide registers: sampled input, output latch, read polarity and pin direction. From these and from a per-pin external pull-down input, it resolves the level of every pin.

A pin is released whenever its direction bit or its output bit is 1. A released pin is pulled up and reads 1 unless the external pull-down for that pin is active. A pin whose direction bit and output bit are both 0 is driven low. The resolved levels are captured into the input register on every clock and are presented on `pin_level_o`. Reads of the input register are passed through the polarity mask. The level output is not.

A two-state sequencer decides what a written byte means:
- `ST_AWAIT_PTR` is entered at reset and on every transaction start. The next written byte there is taken as the register pointer, and the sequencer moves to `ST_STREAM`.
- `ST_STREAM` keeps sending written bytes to the selected register until the next start returns it to `ST_AWAIT_PTR`.
- When a start and a write arrive in the same cycle, the byte is the pointer and the sequencer lands in `ST_STREAM`.

The pointer never advances by itself.

Top module: `pexp_core`

## Requirements
- R1: After reset, the output register reads 0xFF, polarity reads 0x00, direction reads 0xFF, and the input register reads 0xFF. `pin_level_o` is 0xFF and the pointer is 0.
- R2: The first byte written after a transaction start is the pointer, and every later byte of that transaction goes to the selected register. A new start makes the next written byte a pointer again.
- R3: Only pointer bits [1:0] select a register: 0 input, 1 output, 2 polarity, 3 direction. Bits [7:2] are ignored.
- R4: The pointer does not change on reads or data writes. Repeated writes go to one register, and repeated reads return the same register.
- R5: A read at pointer 0 returns the input register XOR polarity. Reads at pointers 1 to 3 return the stored value.
- R6: A data write at pointer 0 changes no register and no pin level.
- R7: For each pin i, the level is 1 when (direction[i] OR output[i]) is 1 and ext_pulldown_i[i] is 0. Otherwise it is 0.
- R8: `pin_level_o` shows a new output or direction value one clock after the edge that wrote it. It follows a change of `ext_pulldown_i` at the first clock edge that samples it.
- R9: `rd_data_o` is registered: it takes the selected value at the edge that samples `rd_stb_i` and holds it until the next read.
- R10: A read in a transaction that has written no pointer uses the pointer kept from the previous transaction.
- R11: The polarity register affects only reads of register 0, never `pin_level_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xact_start_i | input | 1 | Transaction start strobe |
| wr_stb_i | input | 1 | Written byte strobe |
| wr_data_i | input | 8 | Written byte |
| rd_stb_i | input | 1 | Read byte request |
| rd_data_o | output | 8 | Registered read data |
| ext_pulldown_i | input | 8 | Per-pin external pull-down, 1 = pulled low |
| pin_level_o | output | 8 | Resolved pin levels |

## Verification
The assertions check three things on every cycle:
- Pin resolution against the previous cycle's output, direction and pull-down values.
- The polarity-masked input read, and that read data holds between reads.
- That the pointer holds outside write strobes, and that data writes at pointer 0 leave every register alone.

Only the bench's scenarios can show the reset values and the pointer/data split across transaction starts. They also cover upper-bit decode, the carried-over pointer, and the exact cycle in which a write reaches the pin levels.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_POL = 2'd2,
        SEL_DIR = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_AWAIT_PTR = 1'b0,
        ST_STREAM    = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;
endpackage

// File: rtl/pexp_seq.sv
module pexp_seq
    import pexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xact_start,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output reg_sel_e          ptr_o,
    output logic              data_phase_o,
    output reg_wr_t           wr_o
);
    seq_state_e state_q, state_d;
    reg_sel_e   ptr_q, ptr_d;

    // next-state and pointer capture
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (xact_start) begin
            if (wr_stb) begin
                ptr_d   = reg_sel_e'(wr_data[SEL_W-1:0]);
                state_d = ST_STREAM;
            end else begin
                state_d = ST_AWAIT_PTR;
            end
        end else begin
            unique case (state_q)
                ST_AWAIT_PTR: begin
                    if (wr_stb) begin
                        ptr_d   = reg_sel_e'(wr_data[SEL_W-1:0]);
                        state_d = ST_STREAM;
                    end
                end
                ST_STREAM: state_d = ST_STREAM;
                default:   state_d = ST_AWAIT_PTR;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_AWAIT_PTR;
            ptr_q   <= SEL_IN;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        wr_o.we      = wr_stb && !xact_start && (state_q == ST_STREAM);
        wr_o.sel     = ptr_q;
        wr_o.data    = wr_data;
        ptr_o        = ptr_q;
        data_phase_o = (state_q == ST_STREAM);
    end
endmodule

// File: rtl/pexp_pins.sv
module pexp_pins #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] out_i,
    input  logic [NPINS-1:0] dir_i,
    input  logic [NPINS-1:0] ext_pd_i,
    output logic [NPINS-1:0] in_o
);
    logic [NPINS-1:0] resolved;
    logic [NPINS-1:0] in_q;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        // released pins are pulled up unless held low from outside
        assign resolved[g] = (out_i[g] | dir_i[g]) ? ~ext_pd_i[g] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '1;
        else        in_q <= resolved;
    end

    assign in_o = in_q;
endmodule

// File: rtl/pexp_regs.sv
module pexp_regs
    import pexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  reg_wr_t           wr_i,
    input  logic              rd_stb,
    input  reg_sel_e          rd_sel,
    input  logic [BYTE_W-1:0] in_i,
    output logic [BYTE_W-1:0] out_o,
    output logic [BYTE_W-1:0] pol_o,
    output logic [BYTE_W-1:0] dir_o,
    output logic [BYTE_W-1:0] rd_data_o
);
    logic [BYTE_W-1:0] out_q, pol_q, dir_q, rd_q, rd_mux;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            dir_q <= '1;
        end else if (wr_i.we) begin
            unique case (wr_i.sel)
                SEL_OUT: out_q <= wr_i.data;
                SEL_POL: pol_q <= wr_i.data;
                SEL_DIR: dir_q <= wr_i.data;
                SEL_IN:  ;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_IN:  rd_mux = in_i ^ pol_q;
            SEL_OUT: rd_mux = out_q;
            SEL_POL: rd_mux = pol_q;
            SEL_DIR: rd_mux = dir_q;
            default: rd_mux = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_stb) rd_q <= rd_mux;
    end

    assign out_o     = out_q;
    assign pol_o     = pol_q;
    assign dir_o     = dir_q;
    assign rd_data_o = rd_q;
endmodule

// File: rtl/pexp_core.sv
module pexp_core
    import pexp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xact_start_i,
    input  logic              wr_stb_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              rd_stb_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic [BYTE_W-1:0] ext_pulldown_i,
    output logic [BYTE_W-1:0] pin_level_o
);
    reg_sel_e          ptr_w;
    logic              data_phase_w;
    reg_wr_t           wr_w;
    logic [BYTE_W-1:0] out_w, pol_w, dir_w, in_w;

    pexp_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .xact_start   (xact_start_i),
        .wr_stb       (wr_stb_i),
        .wr_data      (wr_data_i),
        .ptr_o        (ptr_w),
        .data_phase_o (data_phase_w),
        .wr_o         (wr_w)
    );

    pexp_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_w),
        .rd_stb    (rd_stb_i),
        .rd_sel    (ptr_w),
        .in_i      (in_w),
        .out_o     (out_w),
        .pol_o     (pol_w),
        .dir_o     (dir_w),
        .rd_data_o (rd_data_o)
    );

    pexp_pins #(.NPINS(BYTE_W)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_i    (out_w),
        .dir_i    (dir_w),
        .ext_pd_i (ext_pulldown_i),
        .in_o     (in_w)
    );

    assign pin_level_o = in_w;
endmodule

// File: rtl/pexp_core_chk.sv
module pexp_core_chk
    import pexp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              xact_start_i,
    input logic              wr_stb_i,
    input logic              rd_stb_i,
    input logic [BYTE_W-1:0] ext_pulldown_i,
    input logic [BYTE_W-1:0] rd_data_o,
    input logic [BYTE_W-1:0] pin_level_o,
    input reg_sel_e          ptr_w,
    input logic              data_phase_w,
    input logic [BYTE_W-1:0] out_w,
    input logic [BYTE_W-1:0] pol_w,
    input logic [BYTE_W-1:0] dir_w
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_pin_resolve_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> pin_level_o == ($past(out_w | dir_w) & ~$past(ext_pulldown_i)));

    assert_input_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rd_stb_i) && $past(ptr_w) == SEL_IN)
            |-> rd_data_o == ($past(pin_level_o) ^ $past(pol_w)));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(rd_stb_i)) |-> $stable(rd_data_o));

    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(wr_stb_i)) |-> $stable(ptr_w));

    assert_input_wr_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_stb_i && !xact_start_i && data_phase_w && ptr_w == SEL_IN))
            |-> ($stable(out_w) && $stable(pol_w) && $stable(dir_w)));
endmodule

bind pexp_core pexp_core_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .xact_start_i   (xact_start_i),
    .wr_stb_i       (wr_stb_i),
    .rd_stb_i       (rd_stb_i),
    .ext_pulldown_i (ext_pulldown_i),
    .rd_data_o      (rd_data_o),
    .pin_level_o    (pin_level_o),
    .ptr_w          (ptr_w),
    .data_phase_w   (data_phase_w),
    .out_w          (out_w),
    .pol_w          (pol_w),
    .dir_w          (dir_w)
);

// File: tb/pexp_core_tb_top.sv
module pexp_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xact_start_i = 1'b0;
    logic       wr_stb_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       rd_stb_i = 1'b0;
    logic [7:0] rd_data_o;
    logic [7:0] ext_pulldown_i = 8'h00;
    logic [7:0] pin_level_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pexp_core dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .xact_start_i   (xact_start_i),
        .wr_stb_i       (wr_stb_i),
        .wr_data_i      (wr_data_i),
        .rd_stb_i       (rd_stb_i),
        .rd_data_o      (rd_data_o),
        .ext_pulldown_i (ext_pulldown_i),
        .pin_level_o    (pin_level_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic start_x();
        @(negedge clk); xact_start_i = 1'b1;
        @(negedge clk); xact_start_i = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); wr_stb_i = 1'b1; wr_data_i = b;
        @(negedge clk); wr_stb_i = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] v);
        @(negedge clk); rd_stb_i = 1'b1;
        @(negedge clk); rd_stb_i = 1'b0;
        v = rd_data_o;
    endtask

    task automatic set_reg(input logic [7:0] p, input logic [7:0] v);
        start_x(); wr_byte(p); wr_byte(v);
    endtask

    task automatic get_reg(input logic [7:0] p, output logic [7:0] v);
        start_x(); wr_byte(p); rd_byte(v);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 pin_level", pin_level_o, 8'hFF);
        get_reg(8'd1, v); chk("R1 output", v, 8'hFF);
        get_reg(8'd2, v); chk("R1 polarity", v, 8'h00);
        get_reg(8'd3, v); chk("R1 direction", v, 8'hFF);
        get_reg(8'd0, v); chk("R1 input", v, 8'hFF);
    endtask

    task automatic t_ptr_then_data();
        logic [7:0] v;
        set_reg(8'd1, 8'hA5);
        get_reg(8'd1, v); chk("R2 output written", v, 8'hA5);
        // restart clears the byte count: 2 must be taken as pointer
        start_x(); wr_byte(8'd1); wr_byte(8'h0F);
        start_x(); wr_byte(8'd2); wr_byte(8'h77);
        get_reg(8'd1, v); chk("R2 output after restart", v, 8'h0F);
        get_reg(8'd2, v); chk("R2 polarity after restart", v, 8'h77);
    endtask

    task automatic t_no_increment();
        logic [7:0] v, w;
        start_x(); wr_byte(8'd2); wr_byte(8'h11); wr_byte(8'h3C);
        get_reg(8'd2, v); chk("R4 repeated writes same reg", v, 8'h3C);
        get_reg(8'd3, v); chk("R4 direction untouched", v, 8'hFF);
        start_x(); wr_byte(8'd1); rd_byte(v); rd_byte(w);
        chk("R4 first read", v, 8'h0F);
        chk("R4 second read same reg", w, 8'h0F);
    endtask

    task automatic t_decode();
        logic [7:0] v;
        set_reg(8'hFE, 8'h5A);
        get_reg(8'd2, v); chk("R3 upper bits ignored on write", v, 8'h5A);
        set_reg(8'd3, 8'hC0);
        get_reg(8'h07, v); chk("R3 upper bits ignored on read", v, 8'hC0);
        set_reg(8'd3, 8'hFF);
        set_reg(8'd2, 8'h00);
    endtask

    task automatic t_resolve();
        set_reg(8'd1, 8'hC3);
        set_reg(8'd3, 8'h00);
        idle(1);
        chk("R7 driven low / output-high released", pin_level_o, 8'hC3);
        @(negedge clk); ext_pulldown_i = 8'h81;
        @(negedge clk);
        chk("R7 pull-down on released pins", pin_level_o, 8'h42);
        set_reg(8'd1, 8'h00);
        set_reg(8'd3, 8'hF0);
        idle(1);
        chk("R7 inputs only", pin_level_o, 8'h70);
        @(negedge clk); ext_pulldown_i = 8'h00;
        @(negedge clk);
    endtask

    task automatic t_polarity();
        logic [7:0] v;
        set_reg(8'd2, 8'hFF);
        idle(1);
        chk("R11 polarity leaves pin level", pin_level_o, 8'hF0);
        get_reg(8'd0, v); chk("R5 input read inverted", v, 8'h0F);
        set_reg(8'd2, 8'h3C);
        get_reg(8'd0, v); chk("R5 input read partial mask", v, 8'hCC);
        get_reg(8'd2, v); chk("R5 polarity read raw", v, 8'h3C);
        set_reg(8'd2, 8'h00);
    endtask

    task automatic t_input_write();
        logic [7:0] v;
        set_reg(8'd0, 8'h00);
        idle(1);
        chk("R6 pin level unchanged", pin_level_o, 8'hF0);
        get_reg(8'd1, v); chk("R6 output unchanged", v, 8'h00);
        get_reg(8'd2, v); chk("R6 polarity unchanged", v, 8'h00);
        get_reg(8'd3, v); chk("R6 direction unchanged", v, 8'hF0);
        get_reg(8'd0, v); chk("R6 input unchanged", v, 8'hF0);
    endtask

    task automatic t_timing();
        start_x(); wr_byte(8'd1);
        wr_byte(8'h0F);
        chk("R8 level before update", pin_level_o, 8'hF0);
        @(negedge clk);
        chk("R8 level one clock after write", pin_level_o, 8'hFF);
        ext_pulldown_i = 8'h24;
        @(negedge clk);
        chk("R8 pull-down at first edge", pin_level_o, 8'hDB);
        ext_pulldown_i = 8'h00;
        @(negedge clk);
    endtask

    task automatic t_rd_hold();
        logic [7:0] v;
        get_reg(8'd3, v);
        chk("R9 read value", v, 8'hF0);
        set_reg(8'd3, 8'h55);
        idle(3);
        chk("R9 read data held", rd_data_o, 8'hF0);
    endtask

    task automatic t_carry();
        logic [7:0] v;
        set_reg(8'd3, 8'hAA);
        start_x(); rd_byte(v);
        chk("R10 pointer kept across transactions", v, 8'hAA);
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ptr_then_data();
        t_no_increment();
        t_decode();
        t_resolve();
        t_polarity();
        t_input_write();
        t_timing();
        t_rd_hold();
        t_carry();
        report();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end
endmodule